// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block holds the byte-addressed register space of a serial-bus real-time clock. The space is 64 bytes. Bytes 0 to 6 are the running time and date in BCD: seconds, minutes, hours, day of week, date, month and year. Byte 7 is a control byte, and bytes 8 to 63 are plain storage. A byte-level slave front end, with the bit-level protocol handled elsewhere, marks the start of each write transfer and hands over write bytes one at a time. It also issues read strobes. The first byte after a start loads the address pointer. Every following data byte, and every read, uses the pointer and then moves it on by one.

A tick input drives the clock. Every `TICKS_PER_SEC` ticks the time advances by one second. The carry ripples through minutes, hours, weekday, date, month and year, and February is 29 days long in years divisible by four. The hours byte can be shown in 12-hour form with a PM flag. The weekday is a free 1-to-7 value that software chooses. The control byte forces some bits to zero. It also holds an oscillator-fault flag that software can clear but never set. Only a hardware fail input sets that flag.

Top module: `rtc_regfile`

## Requirements
- R1: After reset every one of the 64 bytes reads 0x00, the pointer is 0, and `rd_data` is 0x00.
- R2: The first write byte at or after `wr_start` is taken as an address, and its low 6 bits load the pointer. Each later write byte goes to the byte at the pointer. Each read (`rd_req` with no `wr_valid`) returns the byte at the pointer. Both then increment the pointer, which wraps from 63 to 0.
- R3: `rd_data` shows the addressed byte in the cycle after the `rd_req` cycle and holds it until the next read.
- R4: Each `TICKS_PER_SEC`-th tick adds one second. Seconds (byte 0, bits 6:0) roll from 0x59 to 0x00 and carry into minutes (byte 1, bits 6:0). Minutes roll from 0x59 to 0x00 and carry into hours.
- R5: While byte 0 bit 7 (halt) is set, ticks do not advance the time. Writing byte 0 restarts the tick phase, so a full `TICKS_PER_SEC` ticks are needed before the next second.
- R6: Byte 2 bit 6 selects 12-hour display and bit 5 is PM. Internal hour 0 reads as 12 with PM set (0x72). Hours 1 to 12 read as 0x41 to 0x52 with PM clear. Hours 13 to 23 read as 1 to 11 with PM set. In 24-hour mode the byte is the BCD hour 0x00 to 0x23 with bits 7:6 zero.
- R7: A 12-hour write decodes BCD bits 4:0 and adds 12 when bit 5 is set. A result of 24 becomes hour 0. A write with bit 6 clear loads a 24-hour BCD hour from bits 5:0.
- R8: At the rollover from 23:59:59, the hour becomes 0. The weekday (byte 3, 1 to 7) advances, going from 7 back to 1. The BCD date (byte 4) goes past the month length to 0x01 and carries into the month. Months 4, 6, 9 and 11 have 30 days, month 2 has 28 days or 29 when the BCD year divides by 4, and the other months have 31. The month (byte 5) goes from 0x12 to 0x01 and carries into the year (byte 6), which goes from 0x99 to 0x00.
- R9: A write to byte 7 stores the data ANDed with 0xB3, so bits 2, 3 and 6 always read 0.
- R10: Byte 7 bit 5 is the oscillator-fault flag. A write may clear it, but writing 1 leaves it unchanged. A high `osc_fail` sets it, even in the same cycle as a clearing write.
- R11: Bytes 8 to 63 read back exactly the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Start of a write transfer; the next write byte is an address |
| wr_valid | input | 1 | A write byte is present on `wr_data` |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Read one byte at the pointer |
| rd_data | output | 8 | Last byte read |
| tick | input | 1 | Time base pulse, `TICKS_PER_SEC` per second |
| osc_fail | input | 1 | Oscillator failure; sets the fault flag |

## Verification
A stray pointer would show up as a wrong byte on the very next read. A bad carry stays hidden until the second in which the rollover happens, so the bench drives each date boundary (year end, leap February, a 30-day month) up to that second and reads every field one cycle later. A wrong hour encoding or a wrong weekday wrap only appears in 12-hour form or at 7. A tick phase that is not cleared shows one tick early as a seconds value one too high. A fault flag that software could set shows at once on a control-byte read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_BYTES  = 64;
    localparam int ADDR_W     = $clog2(REG_BYTES);
    localparam int TIME_BYTES = 7;
    localparam int CTRL_ADDR  = 7;
    localparam int NVM_BASE   = 8;
    localparam int NVM_BYTES  = REG_BYTES - NVM_BASE;

    localparam logic [7:0] CTRL_KEEP = 8'hB3;
    localparam int         OSF_BIT   = 5;

    // One BCD step on a two-digit value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_bcd(input logic [7:0] yr);
        if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
        case (mon)
            5'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    output logic [ADDR_W-1:0] ptr,
    output logic              data_we,
    output logic              rd_go
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              want_addr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic       addr_now;

    always_comb begin
        st_d     = st_q;
        addr_now = wr_start || st_q.want_addr;
        data_we  = wr_valid && !addr_now;
        rd_go    = rd_req && !wr_valid;
        if (wr_valid && addr_now) begin
            st_d.ptr       = wr_data[ADDR_W-1:0];
            st_d.want_addr = 1'b0;
        end else if (wr_valid || rd_go) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end else if (wr_start) begin
            st_d.want_addr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_we || rd_go) && st_q.ptr == ADDR_W'(REG_BYTES - 1)) |=> (ptr == '0)); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !wr_start && !st_q.want_addr) |=> (ptr == $past(ptr) + 1'b1)); // R2
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       we,
    input  logic [2:0] waddr,
    input  logic [7:0] wdata,
    input  logic [2:0] raddr,
    output logic [7:0] rbyte
);
    localparam int PH_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [7:0]      sec;   // bit 7 halt
        logic [6:0]      min;
        logic [4:0]      hour;  // binary 0..23
        logic            h12;
        logic [2:0]      dow;
        logic [5:0]      date;
        logic [4:0]      mon;
        logic [7:0]      year;
        logic [PH_W-1:0] phase;
    } tk_state_t;

    tk_state_t st_d, st_q;
    logic      time_we, adv, roll_s, roll_m, roll_h, roll_d, roll_mo;
    logic [7:0] dim;

    function automatic logic [7:0] hour_to_bcd(input logic [4:0] h);
        if (h >= 5'd20) return {4'd2, 4'(h - 5'd20)};
        if (h >= 5'd10) return {4'd1, 4'(h - 5'd10)};
        return {4'd0, h[3:0]};
    endfunction

    function automatic logic [7:0] hour_byte(input logic [4:0] h, input logic mode12);
        if (!mode12)       return hour_to_bcd(h);
        if (h == 5'd0)     return 8'h72;
        if (h <= 5'd12)    return 8'h40 | hour_to_bcd(h);
        return 8'h60 | hour_to_bcd(h - 5'd12);
    endfunction

    function automatic logic [4:0] hour_decode(input logic [7:0] b);
        logic [5:0] t;
        if (b[6]) begin
            t = 6'(b[4]) * 6'd10 + 6'(b[3:0]);
            if (b[5]) t = t + 6'd12;
            if (t == 6'd24) t = 6'd0;
        end else begin
            t = 6'(b[5:4]) * 6'd10 + 6'(b[3:0]);
        end
        return t[4:0];
    endfunction

    always_comb begin
        st_d    = st_q;
        time_we = we && (waddr < 3'(TIME_BYTES));
        adv     = 1'b0;
        dim     = month_len(st_q.mon, st_q.year);
        roll_s  = st_q.sec[6:0] >= 7'h59;
        roll_m  = st_q.min >= 7'h59;
        roll_h  = st_q.hour >= 5'd23;
        roll_d  = {2'b00, st_q.date} >= dim;
        roll_mo = st_q.mon >= 5'h12;

        if (tick && !st_q.sec[7] && !time_we) begin
            if (st_q.phase == PH_LAST) begin
                st_d.phase = '0;
                adv        = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end

        if (adv) begin
            st_d.sec = roll_s ? {st_q.sec[7], 7'h00} : {st_q.sec[7], bcd_inc({1'b0, st_q.sec[6:0]})[6:0]};
            if (roll_s) begin
                st_d.min = roll_m ? 7'h00 : bcd_inc({1'b0, st_q.min})[6:0];
                if (roll_m) begin
                    st_d.hour = roll_h ? 5'd0 : st_q.hour + 5'd1;
                    if (roll_h) begin
                        st_d.dow  = (st_q.dow >= 3'd7) ? 3'd1 : st_q.dow + 3'd1;
                        st_d.date = roll_d ? 6'h01 : bcd_inc({2'b00, st_q.date})[5:0];
                        if (roll_d) begin
                            st_d.mon = roll_mo ? 5'h01 : bcd_inc({3'b000, st_q.mon})[4:0];
                            if (roll_mo)
                                st_d.year = (st_q.year >= 8'h99) ? 8'h00 : bcd_inc(st_q.year);
                        end
                    end
                end
            end
        end

        if (time_we) begin
            case (waddr)
                3'd0: begin
                    st_d.sec   = wdata;
                    st_d.phase = '0;
                end
                3'd1: st_d.min  = wdata[6:0];
                3'd2: begin
                    st_d.hour = hour_decode(wdata);
                    st_d.h12  = wdata[6];
                end
                3'd3: st_d.dow  = wdata[2:0];
                3'd4: st_d.date = wdata[5:0];
                3'd5: st_d.mon  = wdata[4:0];
                default: st_d.year = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (raddr)
            3'd0:    rbyte = st_q.sec;
            3'd1:    rbyte = {1'b0, st_q.min};
            3'd2:    rbyte = hour_byte(st_q.hour, st_q.h12);
            3'd3:    rbyte = {5'd0, st_q.dow};
            3'd4:    rbyte = {2'd0, st_q.date};
            3'd5:    rbyte = {3'd0, st_q.mon};
            3'd6:    rbyte = st_q.year;
            default: rbyte = 8'h00;
        endcase
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sec[7] && !time_we) |=> $stable(st_q.sec) && $stable(st_q.min)); // R5
    AST_MIDNIGHT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !time_we && st_q.hour == 5'd23 && st_q.min == 7'h59 && st_q.sec[6:0] == 7'h59)
        |=> (st_q.hour == 5'd0) && (st_q.min == 7'h00)); // R8
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !time_we) |=> $stable(st_q.sec)); // R4
endmodule

// File: rtl/rtc_ctrl_store.sv
module rtc_ctrl_store
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              osc_fail,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rbyte
);
    typedef struct packed {
        logic [7:0] ctrl;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic [7:0] mem_q [NVM_BYTES];
    logic       ctrl_we, nvm_we;
    logic [ADDR_W-1:0] widx, ridx;

    assign ctrl_we = we && (waddr == ADDR_W'(CTRL_ADDR));
    assign nvm_we  = we && (waddr >= ADDR_W'(NVM_BASE));
    assign widx    = waddr - ADDR_W'(NVM_BASE);
    assign ridx    = raddr - ADDR_W'(NVM_BASE);

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl          = wdata & CTRL_KEEP;
            st_d.ctrl[OSF_BIT] = wdata[OSF_BIT] & st_q.ctrl[OSF_BIT];
        end
        if (osc_fail) st_d.ctrl[OSF_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NVM_BYTES; i++) mem_q[i] <= 8'h00;
        end else if (nvm_we) begin
            mem_q[widx] <= wdata;
        end
    end

    always_comb begin
        if (raddr == ADDR_W'(CTRL_ADDR))      rbyte = st_q.ctrl;
        else if (raddr >= ADDR_W'(NVM_BASE))  rbyte = mem_q[ridx];
        else                                  rbyte = 8'h00;
    end

    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ((st_q.ctrl & ~CTRL_KEEP) == 8'h00)); // R9
    AST_OSF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_fail && !st_q.ctrl[OSF_BIT]) |=> !st_q.ctrl[OSF_BIT]); // R10
    AST_OSF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail |=> st_q.ctrl[OSF_BIT]); // R10
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_start,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       rd_req,
    output logic [7:0] rd_data,
    input  logic       tick,
    input  logic       osc_fail
);
    logic [ADDR_W-1:0] ptr;
    logic              data_we, rd_go;
    logic [7:0]        tk_byte, cs_byte, rd_d, rd_q;

    rtc_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_req(rd_req), .ptr(ptr), .data_we(data_we), .rd_go(rd_go)
    );

    rtc_timekeeper #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .we(data_we && (ptr < ADDR_W'(TIME_BYTES))), .waddr(ptr[2:0]), .wdata(wr_data),
        .raddr(ptr[2:0]), .rbyte(tk_byte)
    );

    rtc_ctrl_store u_store (
        .clk(clk), .rst_n(rst_n), .we(data_we), .waddr(ptr), .wdata(wr_data),
        .osc_fail(osc_fail), .raddr(ptr), .rbyte(cs_byte)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_go) rd_d = (ptr < ADDR_W'(TIME_BYTES)) ? tk_byte : cs_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 8'h00;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data)); // R3
endmodule

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;
    logic       clk = 0, rst_n = 0;
    logic       wr_start = 0, wr_valid = 0, rd_req = 0, tick = 0, osc_fail = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       rd_seen = 0;
    int         n_checks = 0, n_fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    rtc_regfile #(.TICKS_PER_SEC(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .tick(tick), .osc_fail(osc_fail)
    );

    always @(posedge clk) rd_seen <= rd_req && !wr_valid;

    // Monitor: compares each read result one cycle after its request.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rd_data !== e) begin
                n_fails++;
                $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
            end
        end
    end

    task automatic set_ptr(input logic [7:0] a);
        @(negedge clk); wr_start = 1; wr_valid = 1; wr_data = a;
        @(negedge clk); wr_start = 0; wr_valid = 0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); wr_valid = 1; wr_data = d;
        @(negedge clk); wr_valid = 0;
    endtask

    task automatic rd_chk(input logic [7:0] e, input string t);
        @(negedge clk); rd_req = 1; exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_req = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
        set_ptr(8'h00);
        wr_byte(s); wr_byte(m); wr_byte(h); wr_byte(w); wr_byte(d); wr_byte(mo); wr_byte(y);
    endtask

    task automatic finish_run();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_checks++;
        if (rd_data !== 8'h00) begin
            n_fails++;
            $display("FAIL R1 rd_data: got %02h expected 00", rd_data);
        end
        for (int i = 0; i < 9; i++) rd_chk(8'h00, "R1 reset byte");

        // R4 R8 year-end rollover, R3 R5 phase
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        ticks(2);
        set_ptr(8'h00); rd_chk(8'h59, "R4 one second");
        ticks(1);
        set_ptr(8'h00); rd_chk(8'h59, "R4 half second");
        ticks(1);
        set_ptr(8'h00);
        rd_chk(8'h00, "R4 sec wrap"); rd_chk(8'h00, "R4 min wrap");
        rd_chk(8'h00, "R8 hour 0");   rd_chk(8'h01, "R8 dow 7 to 1");
        rd_chk(8'h01, "R8 date");     rd_chk(8'h01, "R8 month");
        rd_chk(8'h00, "R8 year 99 to 00");

        // R8 leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        ticks(2);
        set_ptr(8'h03);
        rd_chk(8'h04, "R8 dow step"); rd_chk(8'h29, "R8 leap date"); rd_chk(8'h02, "R8 leap month");
        set_ptr(8'h00); wr_byte(8'h59); wr_byte(8'h59); wr_byte(8'h23);
        ticks(2);
        set_ptr(8'h04); rd_chk(8'h01, "R8 feb end date"); rd_chk(8'h03, "R8 feb end month");
        // R8 30-day month, non-leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
        ticks(2);
        set_ptr(8'h04); rd_chk(8'h01, "R8 april end date"); rd_chk(8'h05, "R8 april end month");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        ticks(2);
        set_ptr(8'h04); rd_chk(8'h01, "R8 nonleap date"); rd_chk(8'h03, "R8 nonleap month");

        // R5 phase restart and halt
        set_ptr(8'h00); wr_byte(8'h10);
        ticks(1);
        set_ptr(8'h00); wr_byte(8'h20);
        ticks(1);
        set_ptr(8'h00); rd_chk(8'h20, "R5 phase cleared by write");
        ticks(1);
        set_ptr(8'h00); rd_chk(8'h21, "R5 second after full phase");
        set_ptr(8'h00); wr_byte(8'h85);
        ticks(4);
        set_ptr(8'h00); rd_chk(8'h85, "R5 halted");

        // R6 R7 12-hour mode
        set_time(8'h59, 8'h59, 8'h71, 8'h01, 8'h10, 8'h01, 8'h20);
        ticks(2);
        set_ptr(8'h02); rd_chk(8'h72, "R6 midnight as 12 PM");
        set_ptr(8'h00); wr_byte(8'h59); wr_byte(8'h59); wr_byte(8'h52);
        set_ptr(8'h02); rd_chk(8'h52, "R7 12 no PM is hour 12");
        ticks(2);
        set_ptr(8'h02); rd_chk(8'h61, "R6 hour 13 as 1 PM");
        set_ptr(8'h00); wr_byte(8'h59); wr_byte(8'h59); wr_byte(8'h72);
        ticks(2);
        set_ptr(8'h02); rd_chk(8'h41, "R7 12 PM decodes to 0");
        set_ptr(8'h02); wr_byte(8'h15);
        set_ptr(8'h02); rd_chk(8'h15, "R7 24-hour write");

        // R9 R10 control byte
        set_ptr(8'h07); wr_byte(8'hFF);
        set_ptr(8'h07); rd_chk(8'h93, "R9 mask, R10 no set");
        @(negedge clk); osc_fail = 1; @(negedge clk); osc_fail = 0;
        set_ptr(8'h07); rd_chk(8'hB3, "R10 fail sets flag");
        set_ptr(8'h07); wr_byte(8'hFF);
        set_ptr(8'h07); rd_chk(8'hB3, "R10 write 1 keeps");
        set_ptr(8'h07); wr_byte(8'h00);
        set_ptr(8'h07); rd_chk(8'h00, "R10 write clears");
        set_ptr(8'h07);
        osc_fail = 1; wr_byte(8'h00); osc_fail = 0;
        set_ptr(8'h07); rd_chk(8'h20, "R10 fail beats clear");

        // R11 storage, R2 wrap and address masking
        set_ptr(8'hC8); wr_byte(8'hA5); wr_byte(8'h5A);
        set_ptr(8'h3F); wr_byte(8'h3C); wr_byte(8'h07);
        set_ptr(8'h08); rd_chk(8'hA5, "R11 byte 8"); rd_chk(8'h5A, "R11 byte 9");
        // separate start and address byte
        @(negedge clk); wr_start = 1; @(negedge clk); wr_start = 0;
        wr_byte(8'h3F);
        rd_chk(8'h3C, "R2 byte 63"); rd_chk(8'h07, "R2 wrap to 0 after write");
        finish_run();
    end
endmodule